// File: doc/BRIEF.md
# Instruction Pair Fusion Detector

This block sits in the decode stage of a 64-bit RISC-V core. Each cycle it looks at two neighbouring 32-bit instruction words, an older one and the younger one that follows it. It decides whether the pair matches one of a fixed set of idioms that the back end may execute as a single macro-op. The idioms are constant builds, PC-relative address builds, zero extensions, bitfield extracts, and address arithmetic feeding a load.

Every idiom requires a strict register chain: the older instruction writes a register other than x0, and the younger instruction both reads that register as its first source (the base, for loads) and writes it again. A per-idiom enable mask lets the core switch each idiom on or off. When several enabled idioms match, a fixed priority selects the kind code. The result is registered, so the decision appears on the outputs one clock edge after the instruction words were presented.

Top module: `fuse_detect`

## Requirements
- R1: While rst_ni is low, fuse_o is 0 and kind_o is 0.
- R2: The outputs show the decision for the inputs sampled at the previous rising clock edge. Whenever fuse_o is 0, kind_o is 0. Whenever fuse_o is 1, kind_o is a code from 1 to 12.
- R3: No pair fuses when old_valid_i or yng_valid_i is low, or when the older rd field (bits 11:7) is x0.
- R4: No pair fuses unless the younger rs1 field (bits 19:15) and the younger rd field (bits 11:7) both equal the older rd.
- R5: Mask bit k enables kind code k+1. A kind whose mask bit is clear never appears on kind_o.
- R6: Kind 1 is LUI (opcode 0110111) followed by ADDI (opcode 0010011, funct3 000) or ADDIW (opcode 0011011, funct3 000). Kind 2 is AUIPC (opcode 0010111) followed by ADDI.
- R7: Kind 3 is SLLI by 48 followed by SRLI by 48. Kind 4 is SLLI by 32 followed by SRLI by 32. SLLI is opcode 0010011 with funct3 001, and SRLI is the same opcode with funct3 101. Both have bits 31:26 equal to zero, and the shift amount is in bits 25:20.
- R8: Kind 5 is SLLI by 32 followed by SRLI by 0 to 31. An arithmetic right shift (bit 30 set) never completes a shift idiom.
- R9: Kind 10 is SLLI followed by SRLI with any shift amounts.
- R10: Kind 6 is ADD (opcode 0110011, funct3 000, funct7 0000000) followed by LD (opcode 0000011, funct3 011) with offset bits 31:20 all zero.
- R11: A following load (opcode 0000011, funct3 000 to 110; funct3 111 is not a load) gives these kinds: kind 7 after ADD or ADD.UW (opcode 0111011, funct3 000, funct7 0000100), kind 8 after AUIPC, kind 9 after LUI, kind 11 after ADDI, and kind 12 after SH1ADD, SH2ADD or SH3ADD (funct7 0010000, funct3 010, 100 or 110, opcode 0110011, or 0111011 for the .UW forms). The load offset may be any value.
- R12: When more than one enabled kind matches, the lowest kind code is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| old_valid_i | input | 1 | Older instruction word is valid |
| old_insn_i | input | 32 | Older instruction word |
| yng_valid_i | input | 1 | Younger instruction word is valid |
| yng_insn_i | input | 32 | Younger instruction word |
| en_mask_i | input | 12 | Per-kind enable; bit k enables kind k+1 |
| fuse_o | output | 1 | Registered: pair fuses |
| kind_o | output | 4 | Registered kind code, 0 when not fusing |

## Verification
The bench builds the block with its default parameters: exact shift amounts of 48 and 32 and a 6-bit shift field. With these values the idioms overlap in known ways. A 48/48 or 32/32 shift pair also satisfies the bitfield-extract idiom, an SRLI by 31 lies just inside the shifted word range, and one by 33 lies just outside it. An ADD followed by LD at offset zero also satisfies the general add-then-load idiom. The bench uses these overlaps, together with narrowed enable masks, to show both the priority and each idiom in isolation.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int unsigned NUM_KIND = 12;
  localparam int unsigned KIND_W   = $clog2(NUM_KIND + 1);
  localparam int unsigned SHAMT_W  = 6;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OPIMMW = 7'b0011011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_OPW    = 7'b0111011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;

  // hit vector bit positions; bit k reports kind code k+1
  localparam int unsigned K_LUI_ADDI   = 0;
  localparam int unsigned K_AUIPC_ADDI = 1;
  localparam int unsigned K_ZEXT_H     = 2;
  localparam int unsigned K_ZEXT_W     = 3;
  localparam int unsigned K_SZEXT_W    = 4;
  localparam int unsigned K_ADD_LD0    = 5;
  localparam int unsigned K_ADD_LOAD   = 6;
  localparam int unsigned K_AUIPC_LOAD = 7;
  localparam int unsigned K_LUI_LOAD   = 8;
  localparam int unsigned K_BFEXT      = 9;
  localparam int unsigned K_ADDI_LOAD  = 10;
  localparam int unsigned K_SHXADD_LD  = 11;

  typedef struct packed {
    logic               lui;
    logic               auipc;
    logic               addi;
    logic               slli;
    logic               add;
    logic               add_uw;
    logic               shxadd;
    logic [4:0]         rd;
    logic [SHAMT_W-1:0] shamt;
  } head_cls_t;

  typedef struct packed {
    logic               addi;
    logic               addiw;
    logic               srli;
    logic               load;
    logic               ld_zero;
    logic [4:0]         rs1;
    logic [4:0]         rd;
    logic [SHAMT_W-1:0] shamt;
  } tail_cls_t;
endpackage

// File: rtl/fuse_head_decode.sv
module fuse_head_decode
  import fuse_pkg::*;
(
  input  logic [31:0] insn_i,
  output head_cls_t   cls_o
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic       unused_rs1;

  assign opc = insn_i[6:0];
  assign f3  = insn_i[14:12];
  assign f7  = insn_i[31:25];
  assign unused_rs1 = ^insn_i[19:15];

  always_comb begin
    cls_o        = '0;
    cls_o.lui    = (opc == OPC_LUI);
    cls_o.auipc  = (opc == OPC_AUIPC);
    cls_o.addi   = (opc == OPC_OPIMM) && (f3 == 3'b000);
    cls_o.slli   = (opc == OPC_OPIMM) && (f3 == 3'b001) && (insn_i[31:20+SHAMT_W] == '0);
    cls_o.add    = (opc == OPC_OP) && (f3 == 3'b000) && (f7 == 7'b0000000);
    cls_o.add_uw = (opc == OPC_OPW) && (f3 == 3'b000) && (f7 == 7'b0000100);
    cls_o.shxadd = ((opc == OPC_OP) || (opc == OPC_OPW)) && (f7 == 7'b0010000) &&
                   ((f3 == 3'b010) || (f3 == 3'b100) || (f3 == 3'b110));
    cls_o.rd     = insn_i[11:7];
    cls_o.shamt  = insn_i[20 +: SHAMT_W];
  end
endmodule

// File: rtl/fuse_tail_decode.sv
module fuse_tail_decode
  import fuse_pkg::*;
(
  input  logic [31:0] insn_i,
  output tail_cls_t   cls_o
);
  logic [6:0] opc;
  logic [2:0] f3;

  assign opc = insn_i[6:0];
  assign f3  = insn_i[14:12];

  always_comb begin
    cls_o         = '0;
    cls_o.addi    = (opc == OPC_OPIMM) && (f3 == 3'b000);
    cls_o.addiw   = (opc == OPC_OPIMMW) && (f3 == 3'b000);
    // bit 30 set would be an arithmetic shift
    cls_o.srli    = (opc == OPC_OPIMM) && (f3 == 3'b101) && (insn_i[31:20+SHAMT_W] == '0);
    cls_o.load    = (opc == OPC_LOAD) && (f3 != 3'b111);
    cls_o.ld_zero = (opc == OPC_LOAD) && (f3 == 3'b011) && (insn_i[31:20] == '0);
    cls_o.rs1     = insn_i[19:15];
    cls_o.rd      = insn_i[11:7];
    cls_o.shamt   = insn_i[20 +: SHAMT_W];
  end
endmodule

// File: rtl/fuse_pair_match.sv
module fuse_pair_match
  import fuse_pkg::*;
#(
  parameter int unsigned ZEXTH_AMT = 48,
  parameter int unsigned ZEXTW_AMT = 32
) (
  input  head_cls_t             head_i,
  input  tail_cls_t             tail_i,
  output logic [NUM_KIND-1:0]   hit_o
);
  localparam logic [SHAMT_W-1:0] AMT_H = SHAMT_W'(ZEXTH_AMT);
  localparam logic [SHAMT_W-1:0] AMT_W = SHAMT_W'(ZEXTW_AMT);

  logic chain;
  logic shift_pair;
  logic [NUM_KIND-1:0] raw;

  assign chain = (head_i.rd != 5'd0) && (tail_i.rs1 == head_i.rd) && (tail_i.rd == head_i.rd);
  assign shift_pair = head_i.slli && tail_i.srli;

  always_comb begin
    raw               = '0;
    raw[K_LUI_ADDI]   = head_i.lui && (tail_i.addi || tail_i.addiw);
    raw[K_AUIPC_ADDI] = head_i.auipc && tail_i.addi;
    raw[K_ZEXT_H]     = shift_pair && (head_i.shamt == AMT_H) && (tail_i.shamt == AMT_H);
    raw[K_ZEXT_W]     = shift_pair && (head_i.shamt == AMT_W) && (tail_i.shamt == AMT_W);
    raw[K_SZEXT_W]    = shift_pair && (head_i.shamt == AMT_W) && (tail_i.shamt < AMT_W);
    raw[K_ADD_LD0]    = head_i.add && tail_i.ld_zero;
    raw[K_ADD_LOAD]   = (head_i.add || head_i.add_uw) && tail_i.load;
    raw[K_AUIPC_LOAD] = head_i.auipc && tail_i.load;
    raw[K_LUI_LOAD]   = head_i.lui && tail_i.load;
    raw[K_BFEXT]      = shift_pair;
    raw[K_ADDI_LOAD]  = head_i.addi && tail_i.load;
    raw[K_SHXADD_LD]  = head_i.shxadd && tail_i.load;
  end

  assign hit_o = raw & {NUM_KIND{chain}};
endmodule

// File: rtl/fuse_prio_pick.sv
module fuse_prio_pick #(
  parameter int unsigned N = 12,
  parameter int unsigned W = $clog2(N + 1)
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] code_o
);
  // lowest index wins; code = index + 1
  always_comb begin
    code_o = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req_i[i]) code_o = W'(i + 1);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/fuse_detect.sv
module fuse_detect
  import fuse_pkg::*;
#(
  parameter int unsigned ZEXTH_AMT = 48,
  parameter int unsigned ZEXTW_AMT = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                old_valid_i,
  input  logic [31:0]         old_insn_i,
  input  logic                yng_valid_i,
  input  logic [31:0]         yng_insn_i,
  input  logic [NUM_KIND-1:0] en_mask_i,
  output logic                fuse_o,
  output logic [KIND_W-1:0]   kind_o
);
  head_cls_t           head_cls;
  tail_cls_t           tail_cls;
  logic [NUM_KIND-1:0] hit;
  logic [NUM_KIND-1:0] req;
  logic                any_d;
  logic [KIND_W-1:0]   kind_d;
  logic                fuse_q;
  logic [KIND_W-1:0]   kind_q;

  fuse_head_decode i_head (.insn_i(old_insn_i), .cls_o(head_cls));
  fuse_tail_decode i_tail (.insn_i(yng_insn_i), .cls_o(tail_cls));

  fuse_pair_match #(
    .ZEXTH_AMT(ZEXTH_AMT),
    .ZEXTW_AMT(ZEXTW_AMT)
  ) i_match (
    .head_i(head_cls),
    .tail_i(tail_cls),
    .hit_o (hit)
  );

  assign req = hit & en_mask_i & {NUM_KIND{old_valid_i & yng_valid_i}};

  fuse_prio_pick #(.N(NUM_KIND), .W(KIND_W)) i_pick (
    .req_i (req),
    .any_o (any_d),
    .code_o(kind_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fuse_q <= 1'b0;
      kind_q <= '0;
    end else begin
      fuse_q <= any_d;
      kind_q <= kind_d;
    end
  end

  assign fuse_o = fuse_q;
  assign kind_o = kind_q;
endmodule

// File: rtl/fuse_detect_chk.sv
module fuse_detect_chk
  import fuse_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                old_valid_i,
  input logic [31:0]         old_insn_i,
  input logic                yng_valid_i,
  input logic [31:0]         yng_insn_i,
  input logic [NUM_KIND-1:0] en_mask_i,
  input logic                fuse_o,
  input logic [KIND_W-1:0]   kind_o
);
  logic [NUM_KIND-1:0] mask_q;
  logic                mask_bit;
  logic                kind_ok;
  logic                srai_tail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= en_mask_i;
  end

  assign kind_ok  = (kind_o != '0) && (kind_o <= KIND_W'(NUM_KIND));
  assign mask_bit = kind_ok ? mask_q[kind_o - KIND_W'(1)] : 1'b0;
  assign srai_tail = (old_insn_i[6:0] == OPC_OPIMM) && (old_insn_i[14:12] == 3'b001) &&
                     (yng_insn_i[6:0] == OPC_OPIMM) && (yng_insn_i[14:12] == 3'b101) &&
                     yng_insn_i[30];

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> (!fuse_o && kind_o == '0)); // R1

  AST_IDLE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fuse_o |-> kind_o == '0); // R2

  AST_KIND_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_o |-> kind_ok); // R2

  AST_VALID_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(old_valid_i && yng_valid_i) |=> !fuse_o); // R3

  AST_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (old_insn_i[11:7] == 5'd0) |=> !fuse_o); // R3

  AST_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((yng_insn_i[19:15] != old_insn_i[11:7]) || (yng_insn_i[11:7] != old_insn_i[11:7]))
    |=> !fuse_o); // R4

  AST_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_o |-> mask_bit); // R5

  AST_NO_SRAI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srai_tail |=> !fuse_o); // R8
endmodule

bind fuse_detect fuse_detect_chk i_fuse_detect_chk (.*);

// File: tb/test_fuse_detect.sv
`timescale 1ns/1ps
module test_fuse_detect;
  import fuse_pkg::*;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                old_valid_i = 1'b0;
  logic [31:0]         old_insn_i = '0;
  logic                yng_valid_i = 1'b0;
  logic [31:0]         yng_insn_i = '0;
  logic [NUM_KIND-1:0] en_mask_i = '0;
  logic                fuse_o;
  logic [KIND_W-1:0]   kind_o;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [NUM_KIND-1:0] ALL = '1;

  always #2 clk_i = ~clk_i;

  fuse_detect i_fuse_detect (.*);

  function automatic logic [31:0] enc_i(logic [11:0] imm, logic [4:0] rs1, logic [2:0] f3,
                                        logic [4:0] rd, logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] enc_u(logic [19:0] imm, logic [4:0] rd, logic [6:0] op);
    return {imm, rd, op};
  endfunction
  function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                        logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] lui(logic [4:0] rd);   return enc_u(20'h12345, rd, 7'b0110111); endfunction
  function automatic logic [31:0] auipc(logic [4:0] rd); return enc_u(20'h00abc, rd, 7'b0010111); endfunction
  function automatic logic [31:0] addi(logic [4:0] rd, logic [4:0] rs1, logic [11:0] imm);
    return enc_i(imm, rs1, 3'b000, rd, 7'b0010011);
  endfunction
  function automatic logic [31:0] addiw(logic [4:0] rd, logic [4:0] rs1);
    return enc_i(12'h7ff, rs1, 3'b000, rd, 7'b0011011);
  endfunction
  function automatic logic [31:0] slli(logic [4:0] rd, logic [4:0] rs1, logic [5:0] sh);
    return enc_i({6'b0, sh}, rs1, 3'b001, rd, 7'b0010011);
  endfunction
  function automatic logic [31:0] srli(logic [4:0] rd, logic [4:0] rs1, logic [5:0] sh);
    return enc_i({6'b0, sh}, rs1, 3'b101, rd, 7'b0010011);
  endfunction
  function automatic logic [31:0] srai(logic [4:0] rd, logic [4:0] rs1, logic [5:0] sh);
    return enc_i({6'b010000, sh}, rs1, 3'b101, rd, 7'b0010011);
  endfunction
  function automatic logic [31:0] load(logic [2:0] f3, logic [4:0] rd, logic [4:0] rs1, logic [11:0] off);
    return enc_i(off, rs1, f3, rd, 7'b0000011);
  endfunction
  function automatic logic [31:0] add(logic [4:0] rd);
    return enc_r(7'b0000000, 5'd2, 5'd1, 3'b000, rd, 7'b0110011);
  endfunction
  function automatic logic [31:0] add_uw(logic [4:0] rd);
    return enc_r(7'b0000100, 5'd2, 5'd1, 3'b000, rd, 7'b0111011);
  endfunction
  function automatic logic [31:0] shadd(logic [2:0] f3, logic uw, logic [4:0] rd);
    return enc_r(7'b0010000, 5'd2, 5'd1, f3, rd, uw ? 7'b0111011 : 7'b0110011);
  endfunction

  task automatic check(input string tag, input logic ef, input logic [KIND_W-1:0] ek);
    n_chk++;
    if (fuse_o !== ef || kind_o !== ek) begin
      n_bad++;
      $display("FAIL %s: fuse=%0b kind=%0d expected fuse=%0b kind=%0d", tag, fuse_o, kind_o, ef, ek);
    end
  endtask

  // drive after a falling edge, capture at the next rising edge, sample at the following falling edge
  task automatic apply(input logic [31:0] o, input logic [31:0] y, input logic [NUM_KIND-1:0] m,
                       input logic vo = 1'b1, input logic vy = 1'b1);
    @(negedge clk_i);
    old_insn_i = o; yng_insn_i = y; en_mask_i = m; old_valid_i = vo; yng_valid_i = vy;
    @(negedge clk_i);
  endtask

  task automatic pair(input string tag, input logic [31:0] o, input logic [31:0] y,
                      input logic [NUM_KIND-1:0] m, input logic [KIND_W-1:0] ek);
    apply(o, y, m);
    check(tag, ek != 0, ek);
  endtask

  task automatic t_reset;
    apply(lui(5'd5), addi(5'd5, 5'd5, 12'h123), ALL);
    check("R1 held in reset", 1'b0, 4'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 first cycle after reset", 1'b1, 4'd1);
  endtask

  task automatic t_timing;
    apply(lui(5'd5), addi(5'd5, 5'd5, 12'h001), ALL);
    @(negedge clk_i);
    old_insn_i = add(5'd9); yng_insn_i = load(3'b011, 5'd9, 5'd9, 12'h000);
    #1 check("R2 output still previous before edge", 1'b1, 4'd1);
    @(negedge clk_i);
    check("R2 output updated after edge", 1'b1, 4'd6);
    pair("R2 no match gives kind 0", add(5'd9), addi(5'd3, 5'd3, 12'h0), ALL, 4'd0);
  endtask

  task automatic t_gating;
    apply(lui(5'd5), addi(5'd5, 5'd5, 12'h1), ALL, 1'b0, 1'b1);
    check("R3 older invalid", 1'b0, 4'd0);
    apply(lui(5'd5), addi(5'd5, 5'd5, 12'h1), ALL, 1'b1, 1'b0);
    check("R3 younger invalid", 1'b0, 4'd0);
    pair("R3 rd x0", lui(5'd0), addi(5'd0, 5'd0, 12'h1), ALL, 4'd0);
  endtask

  task automatic t_chain;
    pair("R4 rs1 differs", lui(5'd5), addi(5'd5, 5'd6, 12'h1), ALL, 4'd0);
    pair("R4 rd differs",  lui(5'd5), addi(5'd6, 5'd5, 12'h1), ALL, 4'd0);
    pair("R4 load base differs", add(5'd9), load(3'b010, 5'd9, 5'd8, 12'h4), ALL, 4'd0);
  endtask

  task automatic t_mask;
    pair("R5 kind1 masked", lui(5'd5), addi(5'd5, 5'd5, 12'h1), ALL & ~12'h001, 4'd0);
    pair("R5 only kind1 enabled", lui(5'd5), addi(5'd5, 5'd5, 12'h1), 12'h001, 4'd1);
  endtask

  task automatic t_const;
    pair("R6 lui+addi",   lui(5'd5), addi(5'd5, 5'd5, 12'h123), ALL, 4'd1);
    pair("R6 lui+addiw",  lui(5'd7), addiw(5'd7, 5'd7), ALL, 4'd1);
    pair("R6 auipc+addi", auipc(5'd6), addi(5'd6, 5'd6, 12'h800), ALL, 4'd2);
    pair("R6 auipc+addiw no", auipc(5'd6), addiw(5'd6, 5'd6), ALL, 4'd0);
  endtask

  task automatic t_zext;
    pair("R7 zext half",  slli(5'd7, 5'd8, 6'd48), srli(5'd7, 5'd7, 6'd48), ALL, 4'd3);
    pair("R7 zext word",  slli(5'd7, 5'd8, 6'd32), srli(5'd7, 5'd7, 6'd32), ALL, 4'd4);
  endtask

  task automatic t_szext;
    pair("R8 shifted srli 31", slli(5'd7, 5'd8, 6'd32), srli(5'd7, 5'd7, 6'd31), ALL, 4'd5);
    pair("R8 shifted srli 0",  slli(5'd7, 5'd8, 6'd32), srli(5'd7, 5'd7, 6'd0), ALL, 4'd5);
    pair("R8 srli 33 not shifted", slli(5'd7, 5'd8, 6'd32), srli(5'd7, 5'd7, 6'd33),
         ALL & ~12'h200, 4'd0);
    pair("R8 srai never", slli(5'd7, 5'd8, 6'd32), srai(5'd7, 5'd7, 6'd32), ALL, 4'd0);
  endtask

  task automatic t_bfext;
    pair("R9 bfext any",  slli(5'd7, 5'd8, 6'd13), srli(5'd7, 5'd7, 6'd50), ALL, 4'd10);
    pair("R9 srli 33 bfext", slli(5'd7, 5'd8, 6'd32), srli(5'd7, 5'd7, 6'd33), ALL, 4'd10);
    pair("R9 half only bfext", slli(5'd7, 5'd8, 6'd48), srli(5'd7, 5'd7, 6'd48), 12'h200, 4'd10);
  endtask

  task automatic t_add_ld;
    pair("R10 add+ld0", add(5'd9), load(3'b011, 5'd9, 5'd9, 12'h000), ALL, 4'd6);
    pair("R10 add+ld nonzero", add(5'd9), load(3'b011, 5'd9, 5'd9, 12'h008), 12'h020, 4'd0);
    pair("R10 add+ld0 kind7 masked", add(5'd9), load(3'b011, 5'd9, 5'd9, 12'h000), 12'h020, 4'd6);
  endtask

  task automatic t_loads;
    pair("R11 add+lb",     add(5'd9), load(3'b000, 5'd9, 5'd9, 12'hfff), ALL, 4'd7);
    pair("R11 add.uw+lhu", add_uw(5'd9), load(3'b101, 5'd9, 5'd9, 12'h010), ALL, 4'd7);
    pair("R11 auipc+lw",   auipc(5'd4), load(3'b010, 5'd4, 5'd4, 12'h100), ALL, 4'd8);
    pair("R11 lui+lbu",    lui(5'd4), load(3'b100, 5'd4, 5'd4, 12'h7f0), ALL, 4'd9);
    pair("R11 addi+lwu",   addi(5'd4, 5'd3, 12'h10), load(3'b110, 5'd4, 5'd4, 12'h4), ALL, 4'd11);
    pair("R11 sh2add+ld",  shadd(3'b100, 1'b0, 5'd4), load(3'b011, 5'd4, 5'd4, 12'h8), ALL, 4'd12);
    pair("R11 sh3add.uw+lh", shadd(3'b110, 1'b1, 5'd4), load(3'b001, 5'd4, 5'd4, 12'h2), ALL, 4'd12);
    pair("R11 sh1add+lb",  shadd(3'b010, 1'b0, 5'd4), load(3'b000, 5'd4, 5'd4, 12'h0), ALL, 4'd12);
    pair("R11 funct3 111 no load", lui(5'd4), load(3'b111, 5'd4, 5'd4, 12'h0), ALL, 4'd0);
  endtask

  task automatic t_prio;
    pair("R12 half over bfext", slli(5'd7, 5'd8, 6'd48), srli(5'd7, 5'd7, 6'd48), ALL, 4'd3);
    pair("R12 add+ld0 over add+load", add(5'd9), load(3'b011, 5'd9, 5'd9, 12'h0), ALL, 4'd6);
    pair("R12 next enabled wins", add(5'd9), load(3'b011, 5'd9, 5'd9, 12'h0), ALL & ~12'h020, 4'd7);
  endtask

  initial begin
    #(4 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_timing();
    t_gating();
    t_chain();
    t_mask();
    t_const();
    t_zext();
    t_szext();
    t_bfext();
    t_add_ld();
    t_loads();
    t_prio();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule